// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading a two-level translation structure out of word-wide memory. A root register supplies the 20-bit frame of a 4 KB-aligned directory. The walker reads one directory entry, then one leaf entry from the page table that the directory entry points to. It combines the leaf frame with the page offset. At each level it checks the present, writable and user-access attribute bits. When a check fails, it ends the walk with a fault code instead of an address.

When an entry in use has a clear accessed flag, the walker writes that entry back with the flag set. On a permitted write access it also sets the dirty flag in the leaf entry. All such write-backs finish before the response appears.

Requests enter on a valid/ready handshake. Only one walk runs at a time: `req_ready` is high only while the walker is idle. The response is held on a valid/ready handshake, and its fields stay stable while `rsp_ready` is low. The memory port is a request/grant interface. A request and its address, write enable and write data are held until granted. Read data returns on `mem_rvalid` in any later cycle. Writes are complete at their grant.

Top module: `pgwalk_top`

## Requirements
- R1: A successful walk returns `rsp_code` 0. `rsp_addr` is the leaf entry's bits [31:12] joined to linear bits [11:0].
- R2: The directory read goes to {root_frame, lin[31:22], 2'b00}. The leaf read goes to {directory entry[31:12], lin[21:12], 2'b00}.
- R3: An entry with bit 0 (present) clear, at either level, ends the walk with `rsp_code` 1. `rsp_addr` is the linear address, and no memory write is made.
- R4: A write access (`req_write`=1) through an entry with bit 1 clear (read-only), at either level, ends the walk with `rsp_code` 2 and no memory write.
- R5: A user access (`req_user`=1) through an entry with bit 2 clear (supervisor-only), at either level, ends the walk with `rsp_code` 2. Code 3 is never produced.
- R6: Each entry used by a successful level whose bit 5 (accessed) is clear is written back to its own address with bit 5 set. An entry whose bit 5 is already set is not written, unless R7 applies.
- R7: On a permitted write access, the leaf entry is written back with bit 6 (dirty) set. The directory entry's bit 6 is never changed.
- R8: Every write-back of a walk is granted before `rsp_valid` rises.
- R9: `req_ready` is high only while idle. It falls the cycle after a request is accepted and stays low until the response is taken.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold. While `mem_req` is high and `mem_gnt` is low, the memory request fields hold.
- R11: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the directory (base address bits [31:12]) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_code | output | 2 | 0 success, 1 not present, 2 protection |
| rsp_addr | output | 32 | Physical address on success, faulting linear address on fault |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench goes after the fault that sits at the directory level. A walker that checks only the leaf would translate through a read-only or supervisor-only directory entry, and return an address where a protection fault belongs. It also repeats walks after the first one has set the accessed flags. A design that writes back regardless would show extra memory writes, and one that forgets the write-back would leave the stored entries unchanged. Dirty-flag placement is checked in memory afterwards: a walker that marked the directory entry dirty, or skipped the leaf, leaves a wrong stored word. Grant stalls and a held response test that the memory and response fields stay stable while blocked.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = WORD_W - OFF_W;

  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_ACCESS  = 5;
  localparam int unsigned BIT_DIRTY   = 6;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_PROTECT = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_RD,
    ST_L1_WAIT,
    ST_L1_WB,
    ST_L2_RD,
    ST_L2_WAIT,
    ST_L2_WB,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pgwalk_entry_eval.sv
module pgwalk_entry_eval
  import pgwalk_pkg::*;
#(
  parameter int unsigned ENT_W = WORD_W
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             acc_write,
  input  logic             acc_user,
  input  logic             leaf_level,
  output flt_e             fault,
  output logic [ENT_W-1:0] entry_upd,
  output logic             needs_wb
);
  always_comb begin
    if (!entry[BIT_PRESENT])
      fault = FLT_ABSENT;
    else if ((acc_write && !entry[BIT_WRITE]) || (acc_user && !entry[BIT_USER]))
      fault = FLT_PROTECT;
    else
      fault = FLT_NONE;
  end

  always_comb begin
    entry_upd = entry;
    entry_upd[BIT_ACCESS] = 1'b1;
    if (leaf_level && acc_write)
      entry_upd[BIT_DIRTY] = 1'b1;
  end

  assign needs_wb = (entry_upd != entry);
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int unsigned FR_W = FRAME_W,
  parameter int unsigned IX_W = IDX_W,
  parameter int unsigned AW   = WORD_W
) (
  input  logic [FR_W-1:0]   root_frame,
  input  logic [FR_W-1:0]   dir_frame,
  input  logic [2*IX_W-1:0] lin_index,
  input  logic              leaf_level,
  output logic [AW-1:0]     word_addr
);
  localparam int unsigned PAD_W = AW - FR_W - IX_W;

  logic [FR_W-1:0] frame_sel;
  logic [IX_W-1:0] index_sel;

  assign frame_sel = leaf_level ? dir_frame : root_frame;
  assign index_sel = leaf_level ? lin_index[IX_W-1:0] : lin_index[2*IX_W-1:IX_W];
  assign word_addr = {frame_sel, index_sel, {PAD_W{1'b0}}};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned AW     = WORD_W,
  parameter int unsigned PG_OFF = OFF_W,
  parameter int unsigned IX_W   = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-PG_OFF-1:0] root_frame,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_lin,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_code,
  output logic [AW-1:0]    rsp_addr,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic             mem_rvalid,
  input  logic [AW-1:0]    mem_rdata
);
  localparam int unsigned FR_W = AW - PG_OFF;

  walk_st_e         st_q;
  logic [AW-1:0]    lin_q;
  logic             wr_q, usr_q;
  logic [FR_W-1:0]  root_q;
  logic [FR_W-1:0]  dir_frame_q;
  logic [AW-1:0]    wb_data_q;
  flt_e             code_q;
  logic [AW-1:0]    out_addr_q;

  logic             leaf_lvl;
  flt_e             ent_fault;
  logic [AW-1:0]    ent_upd;
  logic             ent_wb;
  logic [AW-1:0]    walk_addr;

  assign leaf_lvl = (st_q == ST_L2_RD) || (st_q == ST_L2_WAIT) || (st_q == ST_L2_WB);

  pgwalk_entry_eval #(.ENT_W(AW)) eval_i (
    .entry      (mem_rdata),
    .acc_write  (wr_q),
    .acc_user   (usr_q),
    .leaf_level (leaf_lvl),
    .fault      (ent_fault),
    .entry_upd  (ent_upd),
    .needs_wb   (ent_wb)
  );

  pgwalk_addr_gen #(.FR_W(FR_W), .IX_W(IX_W), .AW(AW)) agen_i (
    .root_frame (root_q),
    .dir_frame  (dir_frame_q),
    .lin_index  (lin_q[AW-1:PG_OFF]),
    .leaf_level (leaf_lvl),
    .word_addr  (walk_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lin_q       <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      root_q      <= '0;
      dir_frame_q <= '0;
      wb_data_q   <= '0;
      code_q      <= FLT_NONE;
      out_addr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          wr_q   <= req_write;
          usr_q  <= req_user;
          root_q <= root_frame;
          st_q   <= ST_L1_RD;
        end
        ST_L1_RD: if (mem_gnt) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid) begin
          wb_data_q <= ent_upd;
          if (ent_fault != FLT_NONE) begin
            code_q     <= ent_fault;
            out_addr_q <= lin_q;
            st_q       <= ST_RESP;
          end else begin
            dir_frame_q <= mem_rdata[AW-1:PG_OFF];
            st_q        <= ent_wb ? ST_L1_WB : ST_L2_RD;
          end
        end
        ST_L1_WB: if (mem_gnt) st_q <= ST_L2_RD;
        ST_L2_RD: if (mem_gnt) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid) begin
          wb_data_q <= ent_upd;
          if (ent_fault != FLT_NONE) begin
            code_q     <= ent_fault;
            out_addr_q <= lin_q;
            st_q       <= ST_RESP;
          end else begin
            code_q     <= FLT_NONE;
            out_addr_q <= {mem_rdata[AW-1:PG_OFF], lin_q[PG_OFF-1:0]};
            st_q       <= ent_wb ? ST_L2_WB : ST_RESP;
          end
        end
        ST_L2_WB: if (mem_gnt) st_q <= ST_RESP;
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_code  = code_q;
  assign rsp_addr  = out_addr_q;
  assign mem_we    = (st_q == ST_L1_WB) || (st_q == ST_L2_WB);
  assign mem_req   = mem_we || (st_q == ST_L1_RD) || (st_q == ST_L2_RD);
  assign mem_addr  = walk_addr;
  assign mem_wdata = wb_data_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_lin,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_code,
  input logic [AW-1:0] rsp_addr,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata
);
  logic [AW-1:0] lin_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) lin_seen <= '0;
    else if (req_valid && req_ready) lin_seen <= req_lin;
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_no_ready_while_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_code)));
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_no_mem_during_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);
  assert_wb_sets_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> (rsp_addr[11:0] == lin_seen[11:0]));
  assert_fault_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_addr == lin_seen));
endmodule

bind pgwalk_top pgwalk_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_lin   (req_lin),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_addr  (rsp_addr),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_addr;
  logic        mem_req, mem_we;
  logic        mem_gnt;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_addr(rsp_addr),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: grant stalls one cycle in four, read data one cycle after grant
  logic [31:0] mem [int unsigned];
  logic [31:0] rd_hist [0:63];
  int unsigned rd_cnt = 0, wr_cnt = 0, gcnt = 0;
  assign mem_gnt = (gcnt[1:0] != 2'b11);

  always @(posedge clk) begin
    gcnt <= gcnt + 1;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_hist[rd_cnt[5:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lin(input int d, input int t, input int o);
    return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
  endfunction

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic        usr;
    logic [1:0]  code;
    logic [31:0] addr;
    logic [1:0]  nwr;
  } vec_t;

  // lin fields: dir index [31:22], table index [21:12], offset [11:0]
  localparam vec_t VECS [0:11] = '{
    '{32'h0040_5ABC, 1'b0, 1'b1, 2'd0, 32'h1234_5ABC, 2'd2}, // R1 R6 both A clear
    '{32'h0040_5123, 1'b1, 1'b1, 2'd0, 32'h1234_5123, 2'd1}, // R7 dirty on leaf
    '{32'h0040_6FFF, 1'b0, 1'b0, 2'd0, 32'h2222_2FFF, 2'd0}, // R6 no wb when A set
    '{32'h0040_7000, 1'b0, 1'b0, 2'd1, 32'h0040_7000, 2'd0}, // R3 leaf absent
    '{32'h0040_8010, 1'b1, 1'b1, 2'd2, 32'h0040_8010, 2'd0}, // R4 leaf read-only
    '{32'h0040_8010, 1'b0, 1'b1, 2'd0, 32'h4444_4010, 2'd0}, // R4 read allowed
    '{32'h0040_9004, 1'b0, 1'b1, 2'd2, 32'h0040_9004, 2'd0}, // R5 leaf supervisor
    '{32'h0040_9004, 1'b1, 1'b0, 2'd0, 32'h5555_5004, 2'd1}, // R7 supervisor write
    '{32'h0080_1007, 1'b1, 1'b0, 2'd2, 32'h0080_1007, 2'd0}, // R4 directory read-only
    '{32'h00C0_1008, 1'b0, 1'b1, 2'd2, 32'h00C0_1008, 2'd0}, // R5 directory supervisor
    '{32'h00C0_1008, 1'b0, 1'b0, 2'd0, 32'h7777_7008, 2'd0}, // R1 supervisor read
    '{32'h0100_1000, 1'b0, 1'b0, 2'd1, 32'h0100_1000, 2'd0}  // R3 directory absent
  };

  task automatic walk(input logic [31:0] l, input logic w, input logic u, input int hold,
                      output logic [1:0] code, output logic [31:0] addr, output int nwr);
    int unsigned wr0;
    logic [31:0] a0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wr0 = wr_cnt;
    req_lin = l; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 ready low after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    code = rsp_code; addr = rsp_addr; nwr = int'(wr_cnt - wr0);
    a0 = rsp_addr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R10 response held", {rsp_valid, rsp_addr[30:0]}, {1'b1, a0[30:0]});
      check("R9 no accept while busy", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [1:0]  c;
    logic [31:0] a;
    int          n;
    int unsigned r0;
    mem[32'h0001_0000] = 32'h0000_0000;
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0001_0008] = 32'h0003_0025;
    mem[32'h0001_000C] = 32'h0004_0023;
    mem[32'h0001_0010] = 32'h0005_0006;
    mem[32'h0002_0014] = 32'h1234_5007;
    mem[32'h0002_0018] = 32'h2222_2027;
    mem[32'h0002_001C] = 32'h3333_3006;
    mem[32'h0002_0020] = 32'h4444_4025;
    mem[32'h0002_0024] = 32'h5555_5023;
    mem[32'h0003_0004] = 32'h6666_6027;
    mem[32'h0004_0004] = 32'h7777_7067;

    repeat (3) @(negedge clk);
    check("R11 reset ready", 32'(req_ready), 32'd1);
    check("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11 reset mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    r0 = rd_cnt;
    foreach (VECS[i]) begin
      walk(VECS[i].lin, VECS[i].wr, VECS[i].usr, 0, c, a, n);
      check($sformatf("R3 R4 R5 code vec%0d", i), 32'(c), 32'(VECS[i].code));
      check($sformatf("R1 addr vec%0d", i), a, VECS[i].addr);
      check($sformatf("R6 R8 writes before rsp vec%0d", i), 32'(n), 32'(VECS[i].nwr));
    end
    check("R2 directory read address", rd_hist[r0[5:0]], 32'h0001_0004);
    check("R2 leaf read address", rd_hist[5'(r0 + 1)], 32'h0002_0014);

    check("R6 directory accessed set", mem[32'h0001_0004], 32'h0002_0027);
    check("R7 leaf dirty set", mem[32'h0002_0014], 32'h1234_5067);
    check("R7 supervisor write dirty", mem[32'h0002_0024], 32'h5555_5063);
    check("R6 set-A entry untouched", mem[32'h0001_000C], 32'h0004_0023);
    check("R3 absent leaf untouched", mem[32'h0002_001C], 32'h3333_3006);

    walk(lin(1, 6, 12'h345), 1'b1, 1'b1, 3, c, a, n);
    check("R10 held response code", 32'(c), 32'd0);
    check("R7 write marks leaf dirty", mem[32'h0002_0018], 32'h2222_2067);
    check("R7 directory dirty unchanged", 32'(mem[32'h0001_0004][6]), 32'd0);

    walk(lin(2, 1, 12'h0), 1'b0, 1'b1, 0, c, a, n);
    check("R6 read through read-only dir", a, 32'h6666_6000);
    check("R6 no writes when A set", 32'(n), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule